// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst into a synchronous memory. A burst opens when either of two address strobes is sampled high: one driven from the processor side, one from the memory controller side. Either strobe captures the external address and the ordering mode. The block then presents that address as the first beat. After that, each cycle in which the advance input is high moves to the next beat. Only the low two address bits are sequenced. The upper bits stay as they were loaded.

Two orderings are supported. With linear order, the low bits count up from the start position and wrap modulo four. With interleaved order, the low bits are the start position XOR the beat number. When neither a strobe nor advance is present, the address and beat index hold. A strobe always takes precedence over advance.

Top module: `burst_addr_seq`

## Requirements
- R1: After synchronous reset, `addr_out` is 0, `beat_idx` is 0 and the captured ordering is linear.
- R2: A cycle with `strobe_cpu` or `strobe_ctl` high (either alone or both) loads `addr_in`. From the next cycle `addr_out` equals the loaded address and `beat_idx` is 0.
- R3: A cycle with no strobe and `advance` high raises `beat_idx` by one. It wraps from 3 back to 0.
- R4: In linear order, `addr_out[1:0]` equals (loaded start bits + `beat_idx`) mod 4. For example, a start of 1 gives 1,2,3,0.
- R5: In interleaved order, `addr_out[1:0]` equals the loaded start bits XOR `beat_idx`. For example, a start of 1 gives 1,0,3,2.
- R6: The ordering is taken from `interleave` in the strobe cycle: 1 selects interleaved and 0 selects linear. Changes to `interleave` between strobes have no effect on `addr_out`.
- R7: Without a strobe, the address bits above the two low bits never change. The wrap of the beat position does not carry into them.
- R8: A cycle with no strobe and `advance` low leaves `addr_out` and `beat_idx` unchanged, whatever `addr_in` carries.
- R9: When a strobe and `advance` are high in the same cycle, the strobe wins. The new address is loaded with `beat_idx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all inputs |
| rst | input | 1 | Synchronous active-high reset |
| strobe_cpu | input | 1 | Processor-side address strobe, starts a burst |
| strobe_ctl | input | 1 | Controller-side address strobe, starts a burst |
| advance | input | 1 | Step to the next beat of the burst |
| interleave | input | 1 | Ordering captured on a strobe: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | BEAT_W | Registered beat number within the burst |

## Verification
The bench builds the block with `ADDR_W` = 6 and the default two-bit beat counter. With these values, all 64 start addresses can be swept under both orderings. This covers every start position together with varied upper bits. Each burst is advanced five times, so every wrap point and the absence of a carry into bit 2 are seen. The ordering input and the address input are flipped during the burst, which exposes any sampling outside the strobe cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst ordering captured at the start of each burst
    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } burst_order_e;

    localparam int DEF_ADDR_W = 15;
    localparam int DEF_BEAT_W = 2;

    // A burst starts on either strobe
    function automatic logic burst_start(input logic cpu, input logic ctl);
        return cpu | ctl;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  addr_d,
    input  burst_order_e       order_d,
    output logic [ADDR_W-1:0]  base_q,
    output burst_order_e       order_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            base_q  <= addr_d;
            order_q <= order_d;
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = DEF_BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = DEF_BEAT_W
) (
    input  burst_order_e      order,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] cnt,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    always_comb begin
        lin_low = start + cnt;
        ilv_low = start ^ cnt;
        low     = (order == ORD_INTERLEAVED) ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BEAT_W = DEF_BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_idx
);

    localparam int UP_W = ADDR_W - BEAT_W;

    logic              load;
    logic [ADDR_W-1:0] base_q;
    burst_order_e      order_q;
    burst_order_e      order_d;
    logic [BEAT_W-1:0] low;

    assign load    = burst_start(strobe_cpu, strobe_ctl);
    assign order_d = interleave ? ORD_INTERLEAVED : ORD_LINEAR;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_d  (addr_in),
        .order_d (order_d),
        .base_q  (base_q),
        .order_q (order_q)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (advance),
        .cnt_q (beat_idx)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order (order_q),
        .start (base_q[BEAT_W-1:0]),
        .cnt   (beat_idx),
        .low   (low)
    );

    generate
        if (UP_W > 0) begin : g_upper
            assign addr_out = {base_q[ADDR_W-1:BEAT_W], low};
        end else begin : g_low_only
            assign addr_out = low;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 15,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_cpu,
    input logic              strobe_ctl,
    input logic              advance,
    input logic              interleave,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [BEAT_W-1:0] beat_idx
);

    logic              stb;
    logic              shadow_ilv;
    logic [BEAT_W-1:0] lo;

    assign stb = strobe_cpu | strobe_ctl;
    assign lo  = addr_out[BEAT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)      shadow_ilv <= 1'b0;
        else if (stb) shadow_ilv <= interleave;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (addr_out == '0) && (beat_idx == '0));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        stb |=> (addr_out == $past(addr_in)) && (beat_idx == '0));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb && advance) |=> beat_idx == BEAT_W'($past(beat_idx) + 1'b1));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb && advance && !shadow_ilv) |=> lo == BEAT_W'($past(lo) + 1'b1));

    // R5
    interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb && advance && shadow_ilv) |=> (lo ^ $past(lo)) == (beat_idx ^ $past(beat_idx)));

    // R7
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb && !advance) |=> $stable(addr_out) && $stable(beat_idx));

    // R9
    strobe_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && advance) |=> beat_idx == '0);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

    localparam int AW = 6;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_cpu = 1'b0;
    logic          strobe_ctl = 1'b0;
    logic          advance = 1'b0;
    logic          interleave = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [BW-1:0] beat_idx;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_base;
    logic          m_ilv;
    logic [BW-1:0] m_cnt;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_burst_addr_seq (
        .clk(clk), .rst(rst), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .advance(advance), .interleave(interleave), .addr_in(addr_in),
        .addr_out(addr_out), .beat_idx(beat_idx)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [BW-1:0] s;
        s = m_base[BW-1:0];
        return {m_base[AW-1:BW], m_ilv ? (s ^ m_cnt) : BW'(s + m_cnt)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        m_base = '0; m_ilv = 1'b0; m_cnt = '0;
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 addr", addr_out, 0);
        check("R1 beat", beat_idx, 0);
        // R1 linear after reset: advance goes 0,1
        advance = 1'b1;
        tick();
        m_cnt = 1;
        check("R1 linear", addr_out, 1);
        advance = 1'b0;

        for (int mode = 0; mode < 2; mode++) begin
            for (int a = 0; a < 64; a++) begin
                // R2 load through alternating strobes
                strobe_cpu = (a % 3) != 1;
                strobe_ctl = (a % 3) != 0;
                advance    = 1'b0;
                interleave = mode[0];
                addr_in    = AW'(a);
                tick();
                m_base = AW'(a); m_ilv = mode[0]; m_cnt = '0;
                check("R2 addr", addr_out, a);
                check("R2 beat", beat_idx, 0);
                strobe_cpu = 1'b0;
                strobe_ctl = 1'b0;
                // R6 ordering and address changes mid-burst ignored
                interleave = ~mode[0];
                addr_in    = ~AW'(a);
                for (int k = 0; k < 5; k++) begin
                    advance = 1'b1;
                    tick();
                    m_cnt = m_cnt + 1'b1;
                    check("R3 beat", beat_idx, m_cnt);
                    check(mode ? "R5 interleaved addr" : "R4 linear addr", addr_out, exp_addr());
                    check("R7 upper", addr_out[AW-1:BW], m_base[AW-1:BW]);
                end
                // R8 hold
                advance = 1'b0;
                tick(); tick();
                check("R8 hold addr", addr_out, exp_addr());
                check("R8 hold beat", beat_idx, m_cnt);
                check("R6 order kept", addr_out, exp_addr());
                // R9 strobe beats advance
                if (a % 8 == 5) begin
                    strobe_ctl = 1'b1;
                    advance    = 1'b1;
                    addr_in    = AW'(a + 7);
                    interleave = mode[0];
                    tick();
                    m_base = AW'(a + 7); m_ilv = mode[0]; m_cnt = '0;
                    check("R9 addr", addr_out, (a + 7) % 64);
                    check("R9 beat", beat_idx, 0);
                    strobe_ctl = 1'b0;
                    advance    = 1'b0;
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule